// File: doc/BRIEF.md
# Display Control Register Bank with Frame-Synchronous Update

This block is a write-only two-wire serial slave. It collects display adjustment settings (gains, black level, cutoff levels, detector and sharpness options) into a bank of staging registers. The staged values never reach the control outputs directly. All of them are copied to the active outputs together, in one clock cycle, when a vertical blanking interval is recognised. A software writer can therefore send settings at any time without tearing a frame.

Vertical blanking is taken from a composite blanking input that also carries short line-rate pulses. A pulse counts as vertical once it has stayed high for a time threshold, which is a cycle count derived from the clock frequency. The copy is skipped while a bus transfer is open between START and STOP. The staged values are then kept for the next qualifying pulse.

SCL and SDA are oversampled by the system clock. The block drives SDA only through a pull-down enable.

Top module: `dispctl_regbank`

## Requirements
- R1: After reset, every active control bit is zero, `commit_pulse` is low and `sda_pull` is low. Every staging register is also zero, so a commit made before any write leaves the outputs at zero.
- R2: An address byte of 0x40 (7-bit address 0x20 with write bit 0) is acknowledged by pulling SDA low during the ninth clock. Any other address byte is not acknowledged, and the bytes that follow it in that transfer are neither acknowledged nor staged. `sda_pull` changes only while SCL is low.
- R3: A data byte written to a valid sub-address is staged. `ctl_active` stays unchanged until a commit. Register n occupies `ctl_active[8n+7:8n]`.
- R4: The byte after the address is the sub-address. Each acknowledged data byte advances the sub-address by one, so a burst fills consecutive registers.
- R5: Data bytes aimed at sub-addresses above 0x0A are not acknowledged and are discarded.
- R6: A blanking pulse shorter than the threshold (VBLANK_US microseconds at CLK_HZ) produces no commit.
- R7: A blanking pulse that stays high long enough causes exactly one commit per pulse. `commit_pulse` is high for one cycle, on the (THRESH+3)-th rising clock edge after `blank_in` rises, with THRESH = CLK_HZ/1e6 × VBLANK_US. All registers update in that same cycle.
- R8: A commit is suppressed while a transfer is open (after START, before STOP). The staged data is kept and applied on the next qualifying pulse after STOP.
- R9: When a sub-address is written more than once before a commit, the last acknowledged value is the one applied.
- R10: Bit 7 of register 0x01 is unused. It is dropped on write and is always zero in `ctl_active[15]`. Register layout: 0x01 holds blank mode in bit 6 and brightness in bits 5:0; 0x05 holds slice level in bits 7:6 and OSD gain in bits 5:0; 0x0A holds four flags in bits 7:4 and sharpness gain in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line level, asynchronous |
| blank_in | input | 1 | Composite blanking, active high, asynchronous |
| sda_pull | output | 1 | High pulls SDA low (acknowledge) |
| ctl_active | output | 8×NUM_REGS | Active control bytes, register n at bits 8n+7:8n |
| commit_pulse | output | 1 | One-cycle strobe when staged data becomes active |

## Verification
Some properties are checked on every cycle:
- the active outputs never move except in a commit cycle;
- no commit follows a cycle with an open transfer;
- every commit follows a synchronised blanking level that is high;
- the strobe lasts one cycle;
- the acknowledge drive changes only while SCL is low;
- the unused bit stays clear.

Other behaviour only the bench scenarios can show:
- which address is acknowledged;
- sub-address auto-increment and the cut-off above 0x0A;
- last-write-wins;
- the exact commit latency;
- short-pulse rejection;
- a deferred commit being delivered after STOP.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_ADDR_ACK,
    RX_SUB,
    RX_SUB_ACK,
    RX_DATA,
    RX_DATA_ACK,
    RX_SKIP
  } rx_state_e;

  // Writable bits per register; register 1 has an unused top bit.
  function automatic logic [REG_W-1:0] field_mask(input int idx);
    return (idx == 1) ? 8'h7F : 8'hFF;
  endfunction

endpackage

// File: rtl/dispctl_i2c_rx.sv
module dispctl_i2c_rx
  import dispctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20,
  parameter int NUM_REGS = 11,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  output logic             busy,
  output logic             scl_level,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [REG_W-1:0] wr_data
);

  localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);

  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;
  logic       scl_s, sda_s;
  logic       start_c, stop_c, rise_c, fall_c;

  rx_state_e  state;
  logic [3:0] bits;
  logic [7:0] shreg;
  logic [7:0] ptr;

  assign scl_s   = scl_ff[1];
  assign sda_s   = sda_ff[1];
  assign start_c = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise_c  = scl_s & ~scl_p;
  assign fall_c  = ~scl_s & scl_p;
  assign scl_level = scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_in};
      sda_ff <= {sda_ff[0], sda_in};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      bits     <= '0;
      shreg    <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      busy     <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        state    <= RX_ADDR;
        bits     <= '0;
        sda_pull <= 1'b0;
        busy     <= 1'b1;
      end else if (stop_c) begin
        state    <= RX_IDLE;
        sda_pull <= 1'b0;
        busy     <= 1'b0;
      end else begin
        case (state)
          RX_ADDR, RX_SUB, RX_DATA: begin
            if (rise_c) begin
              shreg <= {shreg[6:0], sda_s};
              bits  <= bits + 4'd1;
            end else if (fall_c && bits == 4'd8) begin
              bits <= '0;
              if (state == RX_ADDR) begin
                if (shreg == {DEV_ADDR, 1'b0}) begin
                  sda_pull <= 1'b1;
                  state    <= RX_ADDR_ACK;
                end else begin
                  state <= RX_SKIP;
                end
              end else if (state == RX_SUB) begin
                ptr      <= shreg;
                sda_pull <= 1'b1;
                state    <= RX_SUB_ACK;
              end else if (ptr <= LAST_IDX) begin
                sda_pull <= 1'b1;
                state    <= RX_DATA_ACK;
              end else begin
                state <= RX_SKIP;
              end
            end
          end
          RX_ADDR_ACK: if (fall_c) begin
            sda_pull <= 1'b0;
            state    <= RX_SUB;
          end
          RX_SUB_ACK: if (fall_c) begin
            sda_pull <= 1'b0;
            state    <= RX_DATA;
          end
          RX_DATA_ACK: if (fall_c) begin
            sda_pull <= 1'b0;
            state    <= RX_DATA;
            wr_en    <= 1'b1;
            wr_idx   <= ptr[IDX_W-1:0];
            wr_data  <= shreg;
            if (ptr != 8'hFF) ptr <= ptr + 8'd1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dispctl_vblank_det.sv
module dispctl_vblank_det #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int VBLANK_US = 300,
  localparam int THRESH   = (CLK_HZ / 1_000_000) * VBLANK_US,
  localparam int CNT_W    = $clog2(THRESH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic blank_in,
  output logic blank_sync,
  output logic vb_hit
);

  logic [1:0]       blk_ff;
  logic [CNT_W-1:0] cnt;

  assign blank_sync = blk_ff[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_ff <= '0;
      cnt    <= '0;
      vb_hit <= 1'b0;
    end else begin
      blk_ff <= {blk_ff[0], blank_in};
      vb_hit <= 1'b0;
      if (!blk_ff[1]) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(THRESH - 1)) begin
        cnt    <= CNT_W'(THRESH);
        vb_hit <= 1'b1;
      end else if (cnt != CNT_W'(THRESH)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dispctl_stage_bank.sv
module dispctl_stage_bank
  import dispctl_pkg::*;
#(
  parameter int NUM_REGS = 11,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [REG_W-1:0]          wr_data,
  input  logic                      vb_hit,
  input  logic                      busy,
  output logic [NUM_REGS*REG_W-1:0] active,
  output logic                      commit
);

  logic do_commit;
  assign do_commit = vb_hit & ~busy;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] stage_q;
    logic [REG_W-1:0] live_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q <= '0;
        live_q  <= '0;
      end else begin
        if (wr_en && wr_idx == IDX_W'(g)) stage_q <= wr_data & field_mask(g);
        if (do_commit) live_q <= stage_q;
      end
    end

    assign active[g*REG_W +: REG_W] = live_q;
  end

  always_ff @(posedge clk) begin
    if (rst) commit <= 1'b0;
    else     commit <= do_commit;
  end

endmodule

// File: rtl/dispctl_regbank.sv
module dispctl_regbank
  import dispctl_pkg::*;
#(
  parameter int         CLK_HZ    = 100_000_000,
  parameter int         VBLANK_US = 300,
  parameter int         NUM_REGS  = 11,
  parameter logic [6:0] DEV_ADDR  = 7'h20,
  localparam int        IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      scl_in,
  input  logic                      sda_in,
  input  logic                      blank_in,
  output logic                      sda_pull,
  output logic [NUM_REGS*REG_W-1:0] ctl_active,
  output logic                      commit_pulse
);

  logic             xfer_busy;
  logic             scl_sync;
  logic             blank_sync;
  logic             vb_hit;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [REG_W-1:0] wr_data;

  dispctl_i2c_rx #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_rx (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_pull(sda_pull), .busy(xfer_busy), .scl_level(scl_sync),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  dispctl_vblank_det #(.CLK_HZ(CLK_HZ), .VBLANK_US(VBLANK_US)) u_vb (
    .clk(clk), .rst(rst), .blank_in(blank_in),
    .blank_sync(blank_sync), .vb_hit(vb_hit)
  );

  dispctl_stage_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .vb_hit(vb_hit), .busy(xfer_busy), .active(ctl_active), .commit(commit_pulse)
  );

endmodule

// File: rtl/dispctl_regbank_chk.sv
module dispctl_regbank_chk #(
  parameter int NUM_REGS = 11
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  commit_pulse,
  input logic [NUM_REGS*8-1:0] ctl_active,
  input logic                  sda_pull,
  input logic                  xfer_busy,
  input logic                  scl_sync,
  input logic                  blank_sync
);

  p_active_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !commit_pulse |-> $stable(ctl_active));

  p_commit_once_r7: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |=> !commit_pulse);

  p_no_commit_busy_r8: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |-> !$past(xfer_busy));

  p_commit_after_blank_r6: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |-> $past(blank_sync, 2));

  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_sync);

  p_unused_bit_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl_active[15]);

endmodule

bind dispctl_regbank dispctl_regbank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .commit_pulse(commit_pulse), .ctl_active(ctl_active),
  .sda_pull(sda_pull), .xfer_busy(xfer_busy), .scl_sync(scl_sync),
  .blank_sync(blank_sync)
);

// File: tb/dispctl_regbank_test.sv
module dispctl_regbank_test;

  localparam int NREG   = 11;
  localparam int CLK_HZ = 10_000_000;          // scaled so the threshold is short
  localparam int THRESH = (CLK_HZ / 1_000_000) * 300;
  localparam int Q      = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, blank = 1'b0;
  logic sda_pull, commit_pulse;
  logic [NREG*8-1:0] ctl_active;
  wire  sda_line = sda_m & ~sda_pull;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] st [NREG];
  logic [7:0] ac [NREG];

  always #5 clk = ~clk;

  dispctl_regbank #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .blank_in(blank),
    .sda_pull(sda_pull), .ctl_active(ctl_active), .commit_pulse(commit_pulse)
  );

  function automatic logic [7:0] fmask(input int i);
    return (i == 1) ? 8'h7F : 8'hFF;
  endfunction

  function automatic logic [NREG*8-1:0] exp_flat();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = ac[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic i2c_byte(input logic [7:0] b, output bit ack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; wt(Q);
      scl_m = 1'b1; wt(2*Q);
      scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    ack = !sda_line;
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  // Write n bytes from sub; updates the staging model per R4/R5/R9/R10.
  task automatic wr_burst(input logic [7:0] sub, input int n, input logic [7:0] d [4], input bit close);
    bit ack;
    i2c_start();
    i2c_byte(8'h40, ack);
    check(ack, "R2 address ack", 128'(ack), 128'(1));
    i2c_byte(sub, ack);
    check(ack, "R4 subaddress ack", 128'(ack), 128'(1));
    for (int k = 0; k < n; k++) begin
      int idx = int'(sub) + k;
      bit e = (idx < NREG);
      i2c_byte(d[k], ack);
      check(ack == e, "R5 data ack vs range", 128'(ack), 128'(e));
      if (e) st[idx] = d[k] & fmask(idx);
    end
    if (close) i2c_stop();
  endtask

  task automatic vblank(input int len, input bit expect_commit, input string req);
    int first = 0, cnt = 0;
    blank = 1'b1;
    for (int n = 1; n <= len; n++) begin
      @(negedge clk);
      if (commit_pulse) begin
        cnt++;
        if (first == 0) first = n;
      end
    end
    blank = 1'b0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (commit_pulse) cnt++;
    end
    if (expect_commit) begin
      check(first == THRESH + 3, "R7 commit latency", 128'(first), 128'(THRESH + 3));
      check(cnt == 1, "R7 single strobe", 128'(cnt), 128'(1));
      for (int i = 0; i < NREG; i++) ac[i] = st[i];
    end else begin
      check(cnt == 0, req, 128'(cnt), 128'(0));
    end
    check(ctl_active == exp_flat(), req, 128'(ctl_active), 128'(exp_flat()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    bit ack;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NREG; i++) begin st[i] = '0; ac[i] = '0; end
    wt(5);
    rst = 1'b0;
    wt(3);

    // R1 reset state
    check(ctl_active == '0, "R1 active after reset", 128'(ctl_active), 128'(0));
    check(!sda_pull && !commit_pulse, "R1 pull/strobe after reset",
          128'({sda_pull, commit_pulse}), 128'(0));
    vblank(THRESH + 10, 1'b1, "R1 commit of reset staging");

    // R3 staged but not active
    d = '{8'hA5, 8'h00, 8'h00, 8'h00};
    wr_burst(8'h00, 1, d, 1'b1);
    check(ctl_active == exp_flat(), "R3 active held before commit",
          128'(ctl_active), 128'(exp_flat()));

    // R6 short pulse ignored
    vblank(THRESH - 2, 1'b0, "R6 short pulse no commit");
    vblank(THRESH + 10, 1'b1, "R3 commit applies staged");

    // R2 wrong address: nothing acked, nothing staged
    i2c_start();
    i2c_byte(8'h42, ack);
    check(!ack, "R2 foreign address nack", 128'(ack), 128'(0));
    i2c_byte(8'h03, ack);
    check(!ack, "R2 sub after foreign nack", 128'(ack), 128'(0));
    i2c_byte(8'h77, ack);
    check(!ack, "R2 data after foreign nack", 128'(ack), 128'(0));
    i2c_stop();
    vblank(THRESH + 10, 1'b1, "R2 foreign data not staged");

    // R4/R5 burst across the top of the map
    d = '{8'h31, 8'hF9, 8'h44, 8'h00};
    wr_burst(8'h09, 3, d, 1'b1);
    vblank(THRESH + 10, 1'b1, "R5 burst end discarded");

    // R10 unused bit dropped
    d = '{8'hFF, 8'hC3, 8'h00, 8'h00};
    wr_burst(8'h01, 2, d, 1'b1);
    vblank(THRESH + 10, 1'b1, "R10 unused bit cleared");
    check(ctl_active[15:8] == 8'h7F, "R10 register 1 value", 128'(ctl_active[15:8]), 128'(8'h7F));

    // R9 last write wins
    d = '{8'h11, 8'h00, 8'h00, 8'h00};
    wr_burst(8'h07, 1, d, 1'b1);
    d = '{8'h22, 8'h00, 8'h00, 8'h00};
    wr_burst(8'h07, 1, d, 1'b1);
    vblank(THRESH + 10, 1'b1, "R9 latest value applied");
    check(ctl_active[63:56] == 8'h22, "R9 register 7", 128'(ctl_active[63:56]), 128'(8'h22));

    // R8 open transfer defers the commit
    d = '{8'h33, 8'h00, 8'h00, 8'h00};
    wr_burst(8'h02, 1, d, 1'b0);
    vblank(THRESH + 10, 1'b0, "R8 no commit while busy");
    i2c_stop();
    vblank(THRESH + 10, 1'b1, "R8 deferred data applied");

    // random writes
    for (int r = 0; r < 8; r++) begin
      int n = int'($urandom_range(1, 3));
      logic [7:0] s = 8'($urandom_range(0, 10));
      for (int k = 0; k < 4; k++) d[k] = 8'($urandom_range(0, 255));
      wr_burst(s, n, d, 1'b1);
      if (r % 3 == 1) begin
        d[0] = 8'($urandom_range(0, 255));
        wr_burst(s, 1, d, 1'b1);
      end
      vblank(THRESH + 10, 1'b1, "R4 random burst commit");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule